// File: doc/BRIEF.md
# Mixed-Page-Size Translation Lookaside Buffer

This block is a fully associative address translation cache. It maps 32-bit virtual addresses to 32-bit physical addresses. Each slot holds one translation together with its own region-size code. A slot can cover a 1 MB segment, an 8 KB large page or a 4 KB small page, so each slot compares a different number of upper address bits. The lookup is purely combinational. A virtual address presented on the lookup pins gives hit, physical address, permission bits and a multi-hit flag in the same cycle.

New translations arrive on a fill port with a valid/ready handshake. A fill is accepted on a clock edge where both `fill_valid` and `fill_ready` are high. `fill_ready` drops only in a cycle that carries a maintenance command the variant obeys, because maintenance takes priority over a fill on that edge. A fill offered while `fill_ready` is low is simply not taken, and the source must hold it or offer it again. The slot that receives an accepted fill is picked by a round-robin pointer.

Maintenance comes in two forms: clear everything, and clear whatever slots cover a given virtual address. The `DSIDE` parameter selects the variant. The data-side variant (`DSIDE=1`) obeys both forms. The instruction-side variant (`DSIDE=0`) obeys only clear-everything. Fills and maintenance take effect at the next rising clock edge.

Top module: `mps_tlb`

## Requirements
- R1: After reset no lookup hits, `lk_multi` is low and `fill_ready` is high.
- R2: Size code 01 marks a 1 MB segment. It matches when VA[31:20] equals the stored tag, and the physical address is frame bits [31:20] followed by VA[19:0].
- R3: Size code 10 marks an 8 KB page. It matches on VA[31:13], and the physical address is frame bits [31:13] followed by VA[12:0].
- R4: Size code 11 marks a 4 KB page. It matches on VA[31:12], and the physical address is frame bits [31:12] followed by VA[11:0].
- R5: The lookup result is valid in the same cycle as the address. On a miss, `lk_hit`, `lk_pa` and `lk_perm` are all zero.
- R6: Accepted fills write slots 0, 1, … ENTRIES-1 in turn and then wrap to slot 0, replacing the oldest translation.
- R7: `inv_all` invalidates every slot at the next edge and returns the round-robin pointer to slot 0.
- R8: In the data-side variant, `inv_one` invalidates at the next edge every valid slot whose region contains `inv_va`, and it leaves the round-robin pointer where it was.
- R9: In the instruction-side variant, `inv_one` has no effect: slots stay valid and `fill_ready` stays high.
- R10: When several valid slots match, the lowest-numbered one supplies the address and permissions, and `lk_multi` is high. `lk_multi` is low whenever at most one slot matches.
- R11: `fill_ready` is low in any cycle carrying a maintenance command the variant obeys, and a fill offered in that cycle is not written.
- R12: An accepted fill with size code 00 leaves its slot invalid but still takes that slot and advances the pointer.
- R13: On a hit, `lk_perm` returns the permission bits stored with the winning slot, and VA[11:0] always appears unchanged in `lk_pa[11:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Some valid slot matches `lk_va` |
| lk_pa | output | 32 | Translated physical address (zero on miss) |
| lk_perm | output | PERM_W | Permission bits of the winning slot (zero on miss) |
| lk_multi | output | 1 | More than one valid slot matches |
| fill_valid | input | 1 | A translation is offered for installation |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_va | input | 32 | Virtual base of the offered translation (bits 31:12 used) |
| fill_pa | input | 32 | Physical base of the offered translation (bits 31:12 used) |
| fill_size | input | 2 | Region size code: 00 none, 01 1 MB, 10 8 KB, 11 4 KB |
| fill_perm | input | PERM_W | Permission bits stored with the translation |
| inv_all | input | 1 | Invalidate every slot |
| inv_one | input | 1 | Invalidate slots covering `inv_va` (data side only) |
| inv_va | input | 32 | Address for the single-address invalidation (bits 31:12 used) |

## Verification
The bench builds two copies with four slots each, one with `DSIDE=1` and one with `DSIDE=0`, and drives both with the same stimulus. With only four slots, a handful of fills is enough to wrap the round-robin pointer and reach eviction. The same small configuration makes overlapping segment and page slots cheap to set up, which brings the multi-hit and lowest-index cases into reach. Around every installed tag, the bench sweeps probe addresses that flip bits just below and just above each region boundary. It compares every probe against an arithmetic model of both variants, and this exposes mistakes in how many bits each size code compares.

// File: rtl/mps_tlb_pkg.sv
package mps_tlb_pkg;

  localparam int VA_W   = 32;
  localparam int OFS_W  = 12;
  localparam int VPN_W  = VA_W - OFS_W;

  typedef enum logic [1:0] {
    SZ_NONE  = 2'b00,
    SZ_SEG   = 2'b01,
    SZ_LARGE = 2'b10,
    SZ_SMALL = 2'b11
  } region_e;

  // Bits of the 20-bit page number that take part in the tag compare.
  function automatic logic [VPN_W-1:0] vpn_mask(input region_e sz);
    case (sz)
      SZ_SEG:   vpn_mask = 20'hFFF00;
      SZ_LARGE: vpn_mask = 20'hFFFFE;
      SZ_SMALL: vpn_mask = 20'hFFFFF;
      default:  vpn_mask = 20'h00000;
    endcase
  endfunction

endpackage

// File: rtl/mps_tlb_entry.sv
module mps_tlb_entry
  import mps_tlb_pkg::*;
#(
  parameter int PERM_W = 4,
  parameter bit DSIDE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_ppn,
  input  region_e           wr_size,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              clr_all,
  input  logic              clr_one,
  input  logic [VPN_W-1:0]  clr_vpn,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_match,
  output logic [VPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm
);

  region_e             size_q;
  logic [VPN_W-1:0]    tag_q;
  logic [VPN_W-1:0]    frm_q;
  logic [PERM_W-1:0]   perm_q;
  logic [VPN_W-1:0]    cmp_mask;
  logic                valid;
  logic                clr_hit;

  assign cmp_mask = vpn_mask(size_q);
  assign valid    = (size_q != SZ_NONE);
  assign lk_match = valid && (((lk_vpn ^ tag_q) & cmp_mask) == '0);
  assign lk_ppn   = (frm_q & cmp_mask) | (lk_vpn & ~cmp_mask);
  assign lk_perm  = perm_q;

  generate
    if (DSIDE) begin : g_one
      assign clr_hit = clr_one && valid && (((clr_vpn ^ tag_q) & cmp_mask) == '0);
    end else begin : g_no_one
      logic unused_clr;
      assign unused_clr = ^{clr_one, clr_vpn};
      assign clr_hit    = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= SZ_NONE;
      tag_q  <= '0;
      frm_q  <= '0;
      perm_q <= '0;
    end else if (clr_all || clr_hit) begin
      size_q <= SZ_NONE;
    end else if (wr_en) begin
      size_q <= wr_size;
      tag_q  <= wr_vpn;
      frm_q  <= wr_ppn;
      perm_q <= wr_perm;
    end
  end

endmodule

// File: rtl/mps_tlb_prio.sv
module mps_tlb_prio #(
  parameter int N = 32
) (
  input  logic [N-1:0] hits,
  output logic [N-1:0] first,
  output logic         any,
  output logic         multi
);

  // Isolate the lowest set bit; a second set bit remains after clearing it.
  assign first = hits & (~hits + N'(1));
  assign any   = |hits;
  assign multi = |(hits & (hits - N'(1)));

endmodule

// File: rtl/mps_tlb_rr.sv
module mps_tlb_rr #(
  parameter int N  = 32,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  output logic [PW-1:0] ptr
);

  localparam logic [PW-1:0] LAST = PW'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + PW'(1);
    end
  end

endmodule

// File: rtl/mps_tlb.sv
module mps_tlb
  import mps_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PERM_W  = 4,
  parameter bit DSIDE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       lk_va,
  output logic              lk_hit,
  output logic [31:0]       lk_pa,
  output logic [PERM_W-1:0] lk_perm,
  output logic              lk_multi,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [31:0]       fill_va,
  input  logic [31:0]       fill_pa,
  input  logic [1:0]        fill_size,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_all,
  input  logic              inv_one,
  input  logic [31:0]       inv_va
);

  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic              one_cmd;
  logic              fill_go;
  logic [PW-1:0]     vict_ptr;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] sel_vec;
  logic              any_hit;
  logic [VPN_W-1:0]  e_ppn  [ENTRIES];
  logic [PERM_W-1:0] e_perm [ENTRIES];
  logic [VPN_W-1:0]  sel_ppn;
  logic [PERM_W-1:0] sel_perm;
  logic              unused_low;

  assign unused_low = ^{fill_va[OFS_W-1:0], fill_pa[OFS_W-1:0], inv_va[OFS_W-1:0]};

  assign one_cmd    = DSIDE ? inv_one : 1'b0;
  assign fill_ready = !(inv_all || one_cmd);
  assign fill_go    = fill_valid && fill_ready;

  mps_tlb_rr #(.N(ENTRIES), .PW(PW)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (fill_go),
    .clr   (inv_all),
    .ptr   (vict_ptr)
  );

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      mps_tlb_entry #(.PERM_W(PERM_W), .DSIDE(DSIDE)) u_ent (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_go && (vict_ptr == PW'(i))),
        .wr_vpn   (fill_va[VA_W-1:OFS_W]),
        .wr_ppn   (fill_pa[VA_W-1:OFS_W]),
        .wr_size  (region_e'(fill_size)),
        .wr_perm  (fill_perm),
        .clr_all  (inv_all),
        .clr_one  (one_cmd),
        .clr_vpn  (inv_va[VA_W-1:OFS_W]),
        .lk_vpn   (lk_va[VA_W-1:OFS_W]),
        .lk_match (hit_vec[i]),
        .lk_ppn   (e_ppn[i]),
        .lk_perm  (e_perm[i])
      );
    end
  endgenerate

  mps_tlb_prio #(.N(ENTRIES)) u_prio (
    .hits  (hit_vec),
    .first (sel_vec),
    .any   (any_hit),
    .multi (lk_multi)
  );

  always_comb begin
    sel_ppn  = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (sel_vec[i]) begin
        sel_ppn  = sel_ppn  | e_ppn[i];
        sel_perm = sel_perm | e_perm[i];
      end
    end
  end

  assign lk_hit  = any_hit;
  assign lk_pa   = any_hit ? {sel_ppn, lk_va[OFS_W-1:0]} : '0;
  assign lk_perm = sel_perm;

endmodule

// File: rtl/mps_tlb_chk.sv
module mps_tlb_chk #(
  parameter int PERM_W = 4,
  parameter bit DSIDE  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       lk_va,
  input logic              lk_hit,
  input logic [31:0]       lk_pa,
  input logic [PERM_W-1:0] lk_perm,
  input logic              lk_multi,
  input logic              fill_ready,
  input logic              inv_all,
  input logic              inv_one
);

  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == '0 && lk_perm == '0));

  a_r13_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));

  a_r10_multi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);

  a_r7_flush_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lk_hit);

  a_r11_ready_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |-> !fill_ready);

  generate
    if (DSIDE) begin : g_d
      a_r11_ready_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        inv_one |-> !fill_ready);
    end else begin : g_i
      a_r9_one_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_one && !inv_all) |-> fill_ready);
    end
  endgenerate

endmodule

bind mps_tlb mps_tlb_chk #(.PERM_W(PERM_W), .DSIDE(DSIDE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_va      (lk_va),
  .lk_hit     (lk_hit),
  .lk_pa      (lk_pa),
  .lk_perm    (lk_perm),
  .lk_multi   (lk_multi),
  .fill_ready (fill_ready),
  .inv_all    (inv_all),
  .inv_one    (inv_one)
);

// File: tb/mps_tlb_tb.sv
`timescale 1ns/1ps
module mps_tlb_tb;

  localparam int NE = 4;
  localparam int PM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0]   lk_va = '0;
  logic          fill_valid = 1'b0;
  logic [31:0]   fill_va = '0, fill_pa = '0;
  logic [1:0]    fill_size = '0;
  logic [PM-1:0] fill_perm = '0;
  logic          inv_all = 1'b0, inv_one = 1'b0;
  logic [31:0]   inv_va = '0;

  logic          d_hit, d_multi, d_rdy, i_hit, i_multi, i_rdy;
  logic [31:0]   d_pa, i_pa;
  logic [PM-1:0] d_perm, i_perm;

  mps_tlb #(.ENTRIES(NE), .PERM_W(PM), .DSIDE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(d_hit), .lk_pa(d_pa),
    .lk_perm(d_perm), .lk_multi(d_multi), .fill_valid(fill_valid),
    .fill_ready(d_rdy), .fill_va(fill_va), .fill_pa(fill_pa),
    .fill_size(fill_size), .fill_perm(fill_perm), .inv_all(inv_all),
    .inv_one(inv_one), .inv_va(inv_va));

  mps_tlb #(.ENTRIES(NE), .PERM_W(PM), .DSIDE(1'b0)) u_idut (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(i_hit), .lk_pa(i_pa),
    .lk_perm(i_perm), .lk_multi(i_multi), .fill_valid(fill_valid),
    .fill_ready(i_rdy), .fill_va(fill_va), .fill_pa(fill_pa),
    .fill_size(fill_size), .fill_perm(fill_perm), .inv_all(inv_all),
    .inv_one(inv_one), .inv_va(inv_va));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Model per side: 0 = data side, 1 = instruction side.
  int          m_sz  [2][NE];
  logic [19:0] m_tag [2][NE];
  logic [19:0] m_frm [2][NE];
  logic [3:0]  m_pm  [2][NE];
  int          m_ptr [2];

  function automatic logic [19:0] bmask(input int sz);
    case (sz)
      1: return 20'hFFF00;
      2: return 20'hFFFFE;
      3: return 20'hFFFFF;
      default: return 20'h0;
    endcase
  endfunction

  function automatic bit covers(input int s, input int e, input logic [31:0] va);
    return (m_sz[s][e] != 0) &&
           (((va[31:12] ^ m_tag[s][e]) & bmask(m_sz[s][e])) == 20'h0);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic probe(input logic [31:0] va, input string tag);
    @(negedge clk);
    lk_va = va;
    #1;
    for (int s = 0; s < 2; s++) begin
      bit e_hit = 0; int cnt = 0;
      logic [31:0] e_pa = '0; logic [3:0] e_pm = '0;
      logic a_hit, a_multi; logic [31:0] a_pa; logic [3:0] a_pm;
      for (int e = 0; e < NE; e++) begin
        if (covers(s, e, va)) begin
          if (cnt == 0) begin
            logic [19:0] m = bmask(m_sz[s][e]);
            e_pa = {(m_frm[s][e] & m) | (va[31:12] & ~m), va[11:0]};
            e_pm = m_pm[s][e];
          end
          cnt++;
        end
      end
      e_hit = (cnt > 0);
      a_hit   = (s == 0) ? d_hit   : i_hit;
      a_multi = (s == 0) ? d_multi : i_multi;
      a_pa    = (s == 0) ? d_pa    : i_pa;
      a_pm    = (s == 0) ? d_perm  : i_perm;
      chk({a_hit, a_multi, a_pa, a_pm} == {e_hit, (cnt > 1), e_pa, e_pm}, tag,
          $sformatf("side%0d va=%h {hit,multi,pa,perm}", s, va),
          {26'h0, a_hit, a_multi, a_pa, a_pm}, {26'h0, e_hit, (cnt > 1), e_pa, e_pm});
    end
  endtask

  task automatic cmd(input bit fv, input logic [31:0] fva, input logic [31:0] fpa,
                     input int fsz, input logic [3:0] fpm,
                     input bit ia, input bit io, input logic [31:0] iva, input string tag);
    @(negedge clk);
    fill_valid = fv; fill_va = fva; fill_pa = fpa; fill_size = 2'(fsz); fill_perm = fpm;
    inv_all = ia; inv_one = io; inv_va = iva;
    #1;
    chk(d_rdy == !(ia || io), tag, "side0 fill_ready", 64'(d_rdy), 64'(!(ia || io)));
    chk(i_rdy == !ia, tag, "side1 fill_ready", 64'(i_rdy), 64'(!ia));
    @(posedge clk);
    for (int s = 0; s < 2; s++) begin
      bit one_on = (s == 0) && io;
      if (ia) begin
        for (int e = 0; e < NE; e++) m_sz[s][e] = 0;
        m_ptr[s] = 0;
      end else begin
        if (one_on)
          for (int e = 0; e < NE; e++) if (covers(s, e, iva)) m_sz[s][e] = 0;
        if (fv && !one_on) begin
          m_sz[s][m_ptr[s]]  = fsz;
          m_tag[s][m_ptr[s]] = fva[31:12];
          m_frm[s][m_ptr[s]] = fpa[31:12];
          m_pm[s][m_ptr[s]]  = fpm;
          m_ptr[s] = (m_ptr[s] + 1) % NE;
        end
      end
    end
    @(negedge clk);
    fill_valid = 0; inv_all = 0; inv_one = 0;
  endtask

  task automatic fill(input logic [31:0] fva, input logic [31:0] fpa, input int fsz,
                      input logic [3:0] fpm, input string tag);
    cmd(1, fva, fpa, fsz, fpm, 0, 0, '0, tag);
  endtask

  task automatic sweep(input string tag);
    logic [31:0] deltas [8] = '{32'h0, 32'hFFF, 32'h1000, 32'h2000,
                               32'hFF000, 32'h100000, 32'h8000_0000, 32'h0ABC};
    for (int e = 0; e < NE; e++)
      for (int d = 0; d < 8; d++)
        probe({m_tag[0][e], 12'h0} ^ deltas[d], tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      m_ptr[s] = 0;
      for (int e = 0; e < NE; e++) begin
        m_sz[s][e] = 0; m_tag[s][e] = '0; m_frm[s][e] = '0; m_pm[s][e] = '0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset, ready high
    #1;
    chk(d_rdy && i_rdy, "R1", "fill_ready after reset", 64'({d_rdy, i_rdy}), 64'h3);
    probe(32'h0000_0000, "R1");
    probe(32'h1234_5678, "R1 R5");

    // R2 R3 R4 R10 R13: four region kinds, slot 3 overlaps slot 0
    fill(32'h1230_0000, 32'hABC0_0000, 1, 4'h5, "R2");
    fill(32'h4000_2000, 32'h8765_4000, 2, 4'hA, "R3");
    fill(32'h5000_3000, 32'h0001_F000, 3, 4'h3, "R4");
    fill(32'h1230_5000, 32'hDEAD_B000, 3, 4'hC, "R10");
    sweep("R2 R3 R4 R5 R10 R13");

    // R6: fifth fill wraps onto slot 0
    fill(32'h7000_0000, 32'h0F0F_0000, 3, 4'h9, "R6");
    sweep("R6 R10");
    probe(32'h1238_0000, "R6 evicted segment");

    // R8 R9: single-address flush on the large page; pointer stays at slot 1
    cmd(0, '0, '0, 0, '0, 0, 1, 32'h4000_3FFF, "R8 R9");
    sweep("R8 R9");
    fill(32'h6000_1000, 32'h2222_1000, 3, 4'h6, "R8 pointer");
    sweep("R8 R9 pointer");

    // R11 R7: fill offered together with flush-all is dropped
    cmd(1, 32'h3000_0000, 32'h3000_0000, 1, 4'h1, 1, 0, '0, "R7 R11");
    sweep("R7");
    probe(32'h3000_0000, "R11 dropped fill");

    // R7 R6: pointer back at slot 0, then wrap again
    fill(32'h0100_0000, 32'hF000_0000, 1, 4'h2, "R7");
    fill(32'h0200_0000, 32'hE000_0000, 2, 4'h4, "R7");
    fill(32'h0300_0000, 32'hD000_0000, 3, 4'h8, "R7");
    fill(32'h0400_0000, 32'hC000_0000, 1, 4'hF, "R7");
    fill(32'h0500_0000, 32'hB000_0000, 1, 4'h7, "R6 R7 wrap");
    sweep("R6 R7");

    // R12: size 00 takes a slot and stays invalid
    fill(32'h0900_0000, 32'h9000_0000, 0, 4'hE, "R12");
    probe(32'h0900_0000, "R12");
    probe(32'h0200_0000, "R12 displaced");
    sweep("R12");

    // R9 R11: fill with single flush: data side drops it, instruction side takes it
    cmd(1, 32'h0A00_0000, 32'h1111_0000, 3, 4'hB, 0, 1, 32'h0300_0000, "R9 R11");
    probe(32'h0A00_0000, "R9 R11");
    probe(32'h0300_0ABC, "R8 R9");
    sweep("R8 R9 R11");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule